// File: doc/BRIEF.md
# Multichannel Register Access Controller

This block sits between a host microport and a bank of four processing channels. The host sees a small window of three registers: a data port, a channel address register and an access control register. The channel address register is an 8-bit pointer into the internal register space of each channel. The access control register decides which channel or channels a data-port access reaches. It can pick one channel by number, pick half of the bank, or pick all of it. A separate broadcast bit sends every data write to all channels at once.

When broadcast is on, channel data cannot be read back safely. Reads of the data port and of the channel address register then return a fixed value and are flagged invalid. An autoincrement bit advances the channel address after each data-port access. This lets the host stream through a channel's register space without rewriting the pointer. Each host access is a single-cycle strobe. Read data appears on the cycle after the strobe.

Top module: `mchan_access_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 (single-channel mode, channel 0, broadcast and autoincrement off), the channel address is 0x00 and `host_rd_valid` is low.
- R2: Host register numbers are fixed: 0 is the data port, 1 is the channel address register and 2 is the control register. The control register fields are: bit 7 autoincrement, bit 6 broadcast, bits 5:4 group mode, bits 1:0 channel select. Bits 3:2 read as zero. A read of register numbers 3 to 7 returns 0x00 with valid set and invalid clear. A write to register numbers 3 to 7 changes nothing.
- R3: In group mode 0 with broadcast off, a data write drives only the write enable of the channel named by the select bits, and a data read returns that channel's data at the current channel address.
- R4: Group modes 1, 2 and 3 ignore the select bits. Mode 1 targets channels 0 and 1, mode 2 targets channels 2 and 3, and mode 3 targets all four. A data write reaches every targeted channel. A data read returns the lowest-numbered targeted channel.
- R5: With broadcast set, a data write reaches all four channels whatever the group mode and select bits.
- R6: With broadcast set, a read of the data port or of the channel address register returns 0xFF with `host_rd_invalid` high and drives no channel read enable. A read of the control register stays valid.
- R7: With autoincrement set, every data-port access (read or write, including an invalid broadcast read) uses the current channel address and then advances it by one. The address wraps from 0xFF to 0x00.
- R8: With autoincrement clear, the channel address changes only through a host write to register 1.
- R9: `host_rd_valid` is high for exactly the one cycle after a read strobe, and `host_rdata` holds the read result in that cycle.
- R10: If the write and read strobes are both high in one cycle, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_wr | input | 1 | Single-cycle host write strobe |
| host_rd | input | 1 | Single-cycle host read strobe |
| host_addr | input | 3 | Host register number |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after the strobe |
| host_rd_valid | output | 1 | Read result present |
| host_rd_invalid | output | 1 | Read was blocked by broadcast |
| ch_addr | output | 8 | Internal address presented to all channels |
| ch_wdata | output | 8 | Write data presented to all channels |
| ch_wr_en | output | 4 | Per-channel write enable |
| ch_rd_en | output | 4 | Per-channel read enable, one-hot or zero |
| ch_rdata | input | 32 | Read data from channels, channel n in bits 8n+7:8n |

## Verification
The assertions assume that channel read data is presented combinationally from `ch_addr` in the strobe cycle. They also assume that strobes are single-cycle pulses, and they give a simultaneous read and write the write-wins meaning. The bench models the four channels as plain memories that answer within the same cycle. It drives every strobe for exactly one cycle from the falling edge, and it issues overlapped strobes only in a directed case. Random control words are drawn across every group mode, with broadcast and autoincrement in every combination, so all assertion preconditions are reached.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

    // width of the channel select field; the bank holds 2**SEL_W channels
    localparam int SEL_W  = 2;
    localparam int NUM_CH = 1 << SEL_W;

    // host register numbers
    localparam logic [2:0] HREG_DATA  = 3'd0;
    localparam logic [2:0] HREG_CADDR = 3'd1;
    localparam logic [2:0] HREG_CTRL  = 3'd2;

    // control word bit positions
    localparam int CTRL_AINC_BIT  = 7;
    localparam int CTRL_BCAST_BIT = 6;
    localparam int CTRL_GRP_LSB   = 4;

    typedef enum logic [1:0] {
        GRP_ONE  = 2'd0,
        GRP_LOW  = 2'd1,
        GRP_HIGH = 2'd2,
        GRP_ALL  = 2'd3
    } grp_e;

    typedef struct packed {
        logic             autoinc;
        logic             bcast;
        grp_e             grp;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

endpackage

// File: rtl/mcr_target_decode.sv
module mcr_target_decode
    import mcr_pkg::*;
#(
    parameter int NUM_CH_P = NUM_CH
) (
    input  ctrl_t               ctrl,
    output logic [NUM_CH_P-1:0] target
);

    localparam int HALF = NUM_CH_P / 2;

    for (genvar i = 0; i < NUM_CH_P; i++) begin : g_ch
        localparam bit IN_LOW = (i < HALF);
        always_comb begin
            if (ctrl.bcast) begin
                target[i] = 1'b1;
            end else begin
                unique case (ctrl.grp)
                    GRP_ONE:  target[i] = (ctrl.sel == SEL_W'(i));
                    GRP_LOW:  target[i] = IN_LOW;
                    GRP_HIGH: target[i] = !IN_LOW;
                    default:  target[i] = 1'b1;
                endcase
            end
        end
    end

endmodule

// File: rtl/mcr_read_select.sv
module mcr_read_select #(
    parameter int NUM_CH_P = 4,
    parameter int DATA_W   = 8
) (
    input  logic [NUM_CH_P-1:0]        target,
    input  logic [NUM_CH_P*DATA_W-1:0] ch_rdata,
    output logic [NUM_CH_P-1:0]        pick,
    output logic [DATA_W-1:0]          data
);

    // lowest-numbered targeted channel wins
    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        data  = '0;
        for (int i = 0; i < NUM_CH_P; i++) begin
            if (target[i] && !found) begin
                found   = 1'b1;
                pick[i] = 1'b1;
                data    = ch_rdata[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/mcr_addr_step.sv
module mcr_addr_step #(
    parameter int CADDR_W = 8
) (
    input  logic [CADDR_W-1:0] cur,
    input  logic               load,
    input  logic [CADDR_W-1:0] load_val,
    input  logic               step,
    output logic [CADDR_W-1:0] nxt
);

    // natural wrap at the top of the address range
    always_comb begin
        if (load) begin
            nxt = load_val;
        end else if (step) begin
            nxt = cur + CADDR_W'(1);
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/mchan_access_ctrl.sv
module mchan_access_ctrl
    import mcr_pkg::*;
#(
    parameter int          DATA_W    = 8,
    parameter int          CADDR_W   = 8,
    parameter logic [7:0]  BLOCK_VAL = 8'hFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [2:0]               host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [DATA_W-1:0]        host_rdata,
    output logic                     host_rd_valid,
    output logic                     host_rd_invalid,
    output logic [CADDR_W-1:0]       ch_addr,
    output logic [DATA_W-1:0]        ch_wdata,
    output logic [NUM_CH-1:0]        ch_wr_en,
    output logic [NUM_CH-1:0]        ch_rd_en,
    input  logic [NUM_CH*DATA_W-1:0] ch_rdata
);

    localparam logic [NUM_CH-1:0] ALL_CH = '1;

    typedef struct packed {
        ctrl_t               ctrl;
        logic [CADDR_W-1:0]  car;
        logic [DATA_W-1:0]   rdata;
        logic                rd_valid;
        logic                rd_invalid;
    } state_t;

    state_t st_q, st_d;

    // effective accesses: a write masks a same-cycle read
    logic wr_acc, rd_acc, data_acc;
    logic [NUM_CH-1:0] target, pick;
    logic [DATA_W-1:0] sel_data;
    logic [CADDR_W-1:0] car_nxt;

    assign wr_acc   = host_wr;
    assign rd_acc   = host_rd && !host_wr;
    assign data_acc = (wr_acc || rd_acc) && (host_addr == HREG_DATA);

    mcr_target_decode #(.NUM_CH_P(NUM_CH)) u_decode (
        .ctrl   (st_q.ctrl),
        .target (target)
    );

    mcr_read_select #(.NUM_CH_P(NUM_CH), .DATA_W(DATA_W)) u_rsel (
        .target   (target),
        .ch_rdata (ch_rdata),
        .pick     (pick),
        .data     (sel_data)
    );

    mcr_addr_step #(.CADDR_W(CADDR_W)) u_step (
        .cur      (st_q.car),
        .load     (wr_acc && host_addr == HREG_CADDR),
        .load_val (host_wdata[CADDR_W-1:0]),
        .step     (data_acc && st_q.ctrl.autoinc),
        .nxt      (car_nxt)
    );

    // channel side
    assign ch_addr  = st_q.car;
    assign ch_wdata = host_wdata;
    assign ch_wr_en = (wr_acc && host_addr == HREG_DATA) ? target : '0;
    assign ch_rd_en = (rd_acc && host_addr == HREG_DATA && !st_q.ctrl.bcast) ? pick : '0;

    // next-state logic
    always_comb begin
        logic [DATA_W-1:0] word;
        st_d            = st_q;
        st_d.car        = car_nxt;
        st_d.rd_valid   = rd_acc;
        st_d.rd_invalid = 1'b0;

        if (wr_acc && host_addr == HREG_CTRL) begin
            st_d.ctrl.autoinc = host_wdata[CTRL_AINC_BIT];
            st_d.ctrl.bcast   = host_wdata[CTRL_BCAST_BIT];
            st_d.ctrl.grp     = grp_e'(host_wdata[CTRL_GRP_LSB +: 2]);
            st_d.ctrl.sel     = host_wdata[SEL_W-1:0];
        end

        if (rd_acc) begin
            word = '0;
            unique case (host_addr)
                HREG_DATA: begin
                    word = st_q.ctrl.bcast ? DATA_W'(BLOCK_VAL) : sel_data;
                    st_d.rd_invalid = st_q.ctrl.bcast;
                end
                HREG_CADDR: begin
                    if (st_q.ctrl.bcast) begin
                        word = DATA_W'(BLOCK_VAL);
                    end else begin
                        word[CADDR_W-1:0] = st_q.car;
                    end
                    st_d.rd_invalid = st_q.ctrl.bcast;
                end
                HREG_CTRL: begin
                    word[CTRL_AINC_BIT]       = st_q.ctrl.autoinc;
                    word[CTRL_BCAST_BIT]      = st_q.ctrl.bcast;
                    word[CTRL_GRP_LSB +: 2]   = st_q.ctrl.grp;
                    word[SEL_W-1:0]           = st_q.ctrl.sel;
                end
                default: word = '0;
            endcase
            st_d.rdata = word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata      = st_q.rdata;
    assign host_rd_valid   = st_q.rd_valid;
    assign host_rd_invalid = st_q.rd_invalid;

    // ---------------- assertions ----------------
    a_r5_bcast_all: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.bcast && host_wr && host_addr == HREG_DATA) |-> (ch_wr_en == ALL_CH));

    a_r3_single_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.bcast && st_q.ctrl.grp == GRP_ONE) |-> $onehot0(ch_wr_en));

    a_r6_no_read_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.bcast |-> (ch_rd_en == '0));

    a_r6_blocked_value: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_invalid |-> (host_rd_valid && host_rdata == DATA_W'(BLOCK_VAL)));

    a_r7_autoinc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && st_q.ctrl.autoinc) |=> (ch_addr == $past(ch_addr) + CADDR_W'(1)));

    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(host_wr && host_addr == HREG_CADDR) && !(data_acc && st_q.ctrl.autoinc))
        |=> $stable(ch_addr));

    a_r9_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> host_rd_valid);

    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rd) |=> !host_rd_valid);

endmodule

// File: tb/tb_mchan_access_ctrl.sv
`timescale 1ns/1ps
module tb_mchan_access_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_rd_valid, host_rd_invalid;
    logic [7:0]  ch_addr, ch_wdata;
    logic [3:0]  ch_wr_en, ch_rd_en;
    logic [31:0] ch_rdata;

    always #2 clk = ~clk;

    mchan_access_ctrl dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rd_valid(host_rd_valid), .host_rd_invalid(host_rd_invalid),
        .ch_addr(ch_addr), .ch_wdata(ch_wdata), .ch_wr_en(ch_wr_en),
        .ch_rd_en(ch_rd_en), .ch_rdata(ch_rdata)
    );

    // channel models: plain memories answering in the same cycle
    logic [7:0] mem [4][256];
    logic [7:0] exp_mem [4][256];
    always @(posedge clk)
        for (int c = 0; c < 4; c++)
            if (ch_wr_en[c]) mem[c][ch_addr] <= ch_wdata;
    always_comb
        for (int c = 0; c < 4; c++) ch_rdata[c*8 +: 8] = mem[c][ch_addr];

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model of the host-visible state
    logic [7:0] m_ctrl = 8'h00;
    logic [7:0] m_car  = 8'h00;

    function automatic logic [3:0] targets(input logic [7:0] c);
        if (c[6]) return 4'b1111;
        case (c[5:4])
            2'd0: return 4'b0001 << c[1:0];
            2'd1: return 4'b0011;
            2'd2: return 4'b1100;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic int lowest(input logic [3:0] t);
        for (int i = 0; i < 4; i++) if (t[i]) return i;
        return 0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        // model
        if (a == 3'd0) begin
            for (int c = 0; c < 4; c++)
                if (targets(m_ctrl)[c]) exp_mem[c][m_car] = d;
            if (m_ctrl[7]) m_car = m_car + 8'd1;
        end else if (a == 3'd1) m_car = d;
        else if (a == 3'd2) m_ctrl = d & 8'hF3;
    endtask

    task automatic hread(input logic [2:0] a, output logic [7:0] d,
                         output logic v, output logic inv);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata; v = host_rd_valid; inv = host_rd_invalid;
    endtask

    // read with expected values from the model
    task automatic read_chk(input logic [2:0] a, input string req);
        logic [7:0] d, ed; logic v, inv, einv;
        einv = 1'b0;
        case (a)
            3'd0: begin
                if (m_ctrl[6]) begin ed = 8'hFF; einv = 1'b1; end
                else ed = exp_mem[lowest(targets(m_ctrl))][m_car];
            end
            3'd1: begin
                if (m_ctrl[6]) begin ed = 8'hFF; einv = 1'b1; end
                else ed = m_car;
            end
            3'd2: ed = m_ctrl;
            default: ed = 8'h00;
        endcase
        hread(a, d, v, inv);
        if (a == 3'd0 && m_ctrl[7]) m_car = m_car + 8'd1;
        check({req, " data"}, d, ed);
        check({req, " valid"}, v, 1'b1);
        check({req, " invalid"}, inv, einv);
    endtask

    // compare channel memories against the model at one address
    task automatic mem_chk(input logic [7:0] a, input string req);
        for (int c = 0; c < 4; c++) check(req, mem[c][a], exp_mem[c][a]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d; logic v, inv;
        for (int c = 0; c < 4; c++)
            for (int a = 0; a < 256; a++) begin
                mem[c][a]     = 8'(c * 67 + a * 13) ^ 8'h5A;
                exp_mem[c][a] = 8'(c * 67 + a * 13) ^ 8'h5A;
            end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", host_rd_valid, 1'b0);
        check("R1 ch_addr", ch_addr, 8'h00);
        rst_n = 1'b1;
        read_chk(3'd2, "R1 ctrl");
        read_chk(3'd1, "R1 car");

        // R9: valid lasts exactly one cycle
        @(negedge clk); host_rd = 1'b1; host_addr = 3'd2;
        @(negedge clk); host_rd = 1'b0;
        check("R9 valid pulse", host_rd_valid, 1'b1);
        @(negedge clk);
        check("R9 valid drop", host_rd_valid, 1'b0);

        // R3: single channel 2
        hwrite(3'd2, 8'h02); hwrite(3'd1, 8'h10); hwrite(3'd0, 8'hA5);
        mem_chk(8'h10, "R3 single write");
        read_chk(3'd0, "R3 single read");

        // R4: groups ignore select bits
        hwrite(3'd2, 8'h13); hwrite(3'd0, 8'h3C); mem_chk(8'h10, "R4 low pair");
        read_chk(3'd0, "R4 low read");
        hwrite(3'd2, 8'h21); hwrite(3'd0, 8'hC3); mem_chk(8'h10, "R4 high pair");
        read_chk(3'd0, "R4 high read");

        // R5/R6: broadcast
        hwrite(3'd2, 8'h42); hwrite(3'd0, 8'h77); mem_chk(8'h10, "R5 broadcast");
        read_chk(3'd0, "R6 data blocked");
        read_chk(3'd1, "R6 car blocked");
        read_chk(3'd2, "R6 ctrl ok");

        // R7: autoinc wrap, pre-increment address used
        hwrite(3'd2, 8'h80); hwrite(3'd1, 8'hFF); hwrite(3'd0, 8'h99);
        mem_chk(8'hFF, "R7 pre-inc");
        read_chk(3'd1, "R7 wrap");

        // R8: no autoinc, data access keeps address
        hwrite(3'd2, 8'h00); hwrite(3'd0, 8'h11); read_chk(3'd0, "R8 data");
        read_chk(3'd1, "R8 hold");

        // R2: unused registers
        hwrite(3'd5, 8'hFF); read_chk(3'd5, "R2 unused"); read_chk(3'd2, "R2 ctrl kept");
        read_chk(3'd1, "R2 car kept");

        // R10: simultaneous strobes, write wins
        @(negedge clk); host_wr = 1'b1; host_rd = 1'b1; host_addr = 3'd1; host_wdata = 8'h42;
        @(negedge clk); host_wr = 1'b0; host_rd = 1'b0; m_car = 8'h42;
        check("R10 no read", host_rd_valid, 1'b0);
        read_chk(3'd1, "R10 written");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [7:0] a8;
            r = $urandom_range(0, 9);
            case (r)
                0, 1, 2: begin
                    a8 = m_car;
                    hwrite(3'd0, 8'($urandom));
                    mem_chk(a8, "R3/R4/R5 random write");
                end
                3: hwrite(3'd1, 8'($urandom));
                4: hwrite(3'd2, 8'($urandom));
                5, 6, 7: read_chk(3'd0, "R3/R4/R6/R7 random read");
                8: read_chk(3'd1, "R6/R8 random car");
                default: begin
                    logic [2:0] ua;
                    ua = 3'($urandom_range(2, 7));
                    if (ua > 3'd2 && $urandom_range(0, 1) == 1) hwrite(ua, 8'($urandom));
                    read_chk(ua, "R2 random reg");
                end
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule